// File: doc/BRIEF.md
# SAR converter sample sequencer

This block runs a 16-bit successive-approximation converter with a parallel result bus from the host's clock domain. It issues the active-low start strobe and waits for the converter's busy flag, passed through a synchroniser, to fall. It then drives chip-select and read-enable low together, captures the result word, and presents it on `data_o` with a one-cycle `valid_o` pulse. An acquisition gap is timed before the next start. Conversions run back to back while `run_i` is high, or one at a time on each `trig_i` request.

A power-down request never cuts a conversion short. The sequencer finishes the conversion in flight, delivers its word, and only then raises the power-down pin. When the request is withdrawn, a recovery interval is timed before any new start. All intervals are given in nanoseconds and converted to clock cycles from a clock-period parameter. A watchdog flags a conversion whose busy flag outlives a set multiple of the longest conversion time.

Top module: `sar_seq`

## Requirements
- R1: While `rst_ni` is low and after its release with no request, `cnvst_no`, `cs_no` and `rd_no` are high and `pd_o`, `valid_o` and `err_o` are low.
- R2: From idle, a high `run_i` or `trig_i` starts a conversion with a falling edge on `cnvst_no`, but only while synchronised busy is low. A `trig_i` pulse that arrives while a conversion is under way is ignored and adds no conversion.
- R3: With the short-pulse option active (it needs `SHORT_NS >= CLK_NS`), `cnvst_no` is low for exactly one clock. Without it, `cnvst_no` stays low until synchronised busy has been seen high and then low, so it rises only after the conversion has ended.
- R4: After each completed conversion, `cs_no` and `rd_no` are low together for `RD_CYC` clocks. The word on `data_i` is captured at the last of those clocks, and it appears on `data_o` with `valid_o` high for exactly one clock.
- R5: The next falling edge on `cnvst_no` comes no sooner than `ACQ_NS` after busy falls, and never while busy is high.
- R6: A `pd_req_i` that rises during a conversion lets that conversion finish and its word be delivered before `pd_o` rises. When power-down and a start request meet in idle, power-down wins. While `pd_o` is high, no start, chip-select or read strobe is driven.
- R7: After `pd_req_i` falls, `pd_o` falls, and no falling edge on `cnvst_no` occurs for at least `REC_NS`.
- R8: If busy has not fallen within `WDOG_MULT` times `CONV_NS` of the start, `err_o` pulses for one clock and no `valid_o` is given for that conversion. The sequencer then continues with the acquisition gap and can start again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Free-run enable: convert back to back |
| trig_i | input | 1 | Single-conversion request, taken only in idle |
| pd_req_i | input | 1 | Power-down request |
| busy_i | input | 1 | Converter busy flag (asynchronous) |
| data_i | input | DATA_W | Converter parallel result bus |
| cnvst_no | output | 1 | Conversion start strobe, active low |
| cs_no | output | 1 | Converter chip-select, active low |
| rd_no | output | 1 | Converter read-enable, active low |
| pd_o | output | 1 | Converter power-down pin |
| valid_o | output | 1 | One-cycle pulse marking a new word on `data_o` |
| data_o | output | DATA_W | Last captured conversion result |
| err_o | output | 1 | One-cycle pulse when the busy watchdog expires |

## Verification
The interesting collision is a power-down request that lands while a conversion is in flight or in the same cycle a start is due. The bench raises `pd_req_i` at random offsets during free-running conversion. At the moment `pd_o` rises, it checks that the behavioural converter is idle and that every completed conversion has produced a matching `valid_o` word. Two converter models count any start while power-down is held, any start during busy or inside the acquisition gap, any strobe rise in the forbidden window, and any start too soon after recovery. The short-pulse and held-strobe variants run side by side on the same stimulus.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_CONVERT,
    ST_READ,
    ST_ACQUIRE,
    ST_POWERDOWN,
    ST_RECOVER
  } seq_state_e;

  // ceil(ns / clk_ns), never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[N-2:0], d_i};
  end

  assign q_o = sr_q[N-1];
endmodule

// File: rtl/sar_timer.sv
`timescale 1ns/1ps
module sar_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_count_down_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
module sar_seq #(
  parameter int DATA_W      = 16,
  parameter int CLK_NS      = 5,
  parameter int SHORT_PULSE = 1,
  parameter int SHORT_NS    = 40,
  parameter int ACQ_NS      = 385,
  parameter int CONV_NS     = 600,
  parameter int WDOG_MULT   = 4,
  parameter int REC_NS      = 5000000,
  parameter int RD_CYC      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              trig_i,
  input  logic              pd_req_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cnvst_no,
  output logic              cs_no,
  output logic              rd_no,
  output logic              pd_o,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  import sar_seq_pkg::*;

  localparam int  ACQ_CYC   = ns_to_cyc(ACQ_NS, CLK_NS);
  localparam int  WDOG_CYC  = ns_to_cyc(CONV_NS * WDOG_MULT, CLK_NS);
  localparam int  REC_CYC   = ns_to_cyc(REC_NS, CLK_NS);
  localparam int  READ_CYC  = (RD_CYC < 1) ? 1 : RD_CYC;
  localparam int  MAX_CYC   = imax(imax(ACQ_CYC, WDOG_CYC), imax(REC_CYC, READ_CYC));
  localparam int  CNT_W     = $clog2(MAX_CYC + 1);
  localparam bit  USE_SHORT = (SHORT_PULSE != 0) && (SHORT_NS >= CLK_NS);

  seq_state_e state_q, nxt;
  logic busy_s, busy_seen_q, tmr_zero, tmr_load, conv_done, wd_trip;
  logic [CNT_W-1:0] tmr_val;

  sar_sync #(.STAGES(SYNC_STAGES)) u_busy_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(busy_i), .q_o(busy_s)
  );

  sar_timer #(.W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
  );

  assign conv_done = busy_seen_q && !busy_s;

  always_comb begin
    nxt     = state_q;
    wd_trip = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pd_req_i)                        nxt = ST_POWERDOWN;
        else if ((run_i || trig_i) && !busy_s) nxt = ST_START;
      end
      ST_START:   nxt = ST_CONVERT;
      ST_CONVERT: begin
        if (conv_done)     nxt = ST_READ;
        else if (tmr_zero) begin
          nxt     = ST_ACQUIRE;
          wd_trip = 1'b1;
        end
      end
      ST_READ:      if (tmr_zero)  nxt = ST_ACQUIRE;
      ST_ACQUIRE:   if (tmr_zero)  nxt = ST_IDLE;
      ST_POWERDOWN: if (!pd_req_i) nxt = ST_RECOVER;
      ST_RECOVER:   if (tmr_zero)  nxt = ST_IDLE;
      default:                     nxt = ST_IDLE;
    endcase
  end

  // timer reloads on every state change with the length of the new state
  assign tmr_load = (nxt != state_q);
  always_comb begin
    unique case (nxt)
      ST_CONVERT: tmr_val = CNT_W'(WDOG_CYC - 1);
      ST_READ:    tmr_val = CNT_W'(READ_CYC - 1);
      ST_ACQUIRE: tmr_val = CNT_W'(ACQ_CYC - 1);
      ST_RECOVER: tmr_val = CNT_W'(REC_CYC - 1);
      default:    tmr_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      busy_seen_q <= 1'b0;
      cnvst_no    <= 1'b1;
      cs_no       <= 1'b1;
      rd_no       <= 1'b1;
      pd_o        <= 1'b0;
      valid_o     <= 1'b0;
      data_o      <= '0;
      err_o       <= 1'b0;
    end else begin
      state_q <= nxt;
      if (state_q == ST_START)                busy_seen_q <= 1'b0;
      else if (state_q == ST_CONVERT && busy_s) busy_seen_q <= 1'b1;
      // outputs follow the next state so they leave flops glitch-free
      cnvst_no <= !((nxt == ST_START) || (!USE_SHORT && nxt == ST_CONVERT));
      cs_no    <= (nxt != ST_READ);
      rd_no    <= (nxt != ST_READ);
      pd_o     <= (nxt == ST_POWERDOWN);
      valid_o  <= (state_q == ST_READ) && tmr_zero;
      err_o    <= wd_trip;
      if (state_q == ST_READ && tmr_zero) data_o <= data_i;
    end
  end

  p_start_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cnvst_no) |-> (!busy_s && cs_no && rd_no && !pd_o));

  if (USE_SHORT) begin : g_short
    p_short_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cnvst_no |=> cnvst_no);
  end else begin : g_long
    p_late_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cnvst_no) |-> (!busy_s || err_o));
  end

  p_read_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($past(!cs_no) && $past(!rd_no)));

  p_valid_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_pd_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_o |-> (cnvst_no && cs_no && rd_no));

  p_err_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_err_no_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o);
endmodule

// File: tb/sar_seq_tb_top.sv
`timescale 1ns/1ps
module sar_adc_model #(
  parameter int REC_NS = 2000
) (
  input  logic        cnvst_n,
  input  logic        cs_n,
  input  logic        rd_n,
  input  logic        pd,
  input  logic        hang,
  output logic        busy,
  output wire  [15:0] data
);
  logic [15:0] word;
  int nconv, starts, overlap, win_viol, acq_viol, pd_viol, rec_viol;
  realtime t_fall, t_bfall, t_pdfall;
  bit pd_pend, conv_on;
  event go_ev;

  initial begin
    busy = 1'b0; word = '0; nconv = 0; starts = 0; overlap = 0; win_viol = 0;
    acq_viol = 0; pd_viol = 0; rec_viol = 0; t_fall = 0.0; t_bfall = -1000.0;
    t_pdfall = 0.0; pd_pend = 0; conv_on = 0;
  end

  assign data = (!cs_n && !rd_n) ? word : 'z;

  always @(negedge cnvst_n) begin
    starts++;
    if (conv_on) overlap++;
    if ($realtime - t_bfall < 385.0) acq_viol++;
    if (pd) pd_viol++;
    if (pd_pend && ($realtime - t_pdfall < real'(REC_NS))) rec_viol++;
    pd_pend = 0;
    t_fall  = $realtime;
    if (!conv_on) begin
      conv_on = 1;
      -> go_ev;
    end
  end

  always @(go_ev) begin
    #5 busy = 1'b1;
    #(hang ? 2600 : int'($urandom_range(595, 395)));
    word    = 16'($urandom);
    busy    = 1'b0;
    nconv++;
    t_bfall = $realtime;
    conv_on = 0;
  end

  always @(posedge cnvst_n) if (conv_on && ($realtime - t_fall > 40.0)) win_viol++;
  always @(posedge pd) if (conv_on) pd_viol++;
  always @(negedge pd) begin
    t_pdfall = $realtime;
    pd_pend  = 1;
  end
endmodule

module sar_seq_tb_top;
  localparam int REC_NS = 2000;
  localparam int REC_CYC = REC_NS / 5;

  logic clk = 1'b0;
  logic rst_n, run, trig, pd_req, hang0;
  always #2.5 clk = ~clk;

  logic cn0, cs0, rd0, pd0, v0, e0, b0;
  logic cn1, cs1, rd1, pd1, v1, e1, b1;
  logic [15:0] do0, do1;
  wire  [15:0] di0, di1;

  int n_tests = 0, n_fail = 0;
  int vcnt0 = 0, vcnt1 = 0, ecnt0 = 0, ecnt1 = 0;
  bit done_flag = 0;

  sar_seq #(.SHORT_PULSE(1), .REC_NS(REC_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .trig_i(trig), .pd_req_i(pd_req),
    .busy_i(b0), .data_i(di0), .cnvst_no(cn0), .cs_no(cs0), .rd_no(rd0),
    .pd_o(pd0), .valid_o(v0), .data_o(do0), .err_o(e0));

  sar_seq #(.SHORT_PULSE(0), .REC_NS(REC_NS)) dut_l_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .trig_i(trig), .pd_req_i(pd_req),
    .busy_i(b1), .data_i(di1), .cnvst_no(cn1), .cs_no(cs1), .rd_no(rd1),
    .pd_o(pd1), .valid_o(v1), .data_o(do1), .err_o(e1));

  sar_adc_model #(.REC_NS(REC_NS)) mdl0 (
    .cnvst_n(cn0), .cs_n(cs0), .rd_n(rd0), .pd(pd0), .hang(hang0), .busy(b0), .data(di0));
  sar_adc_model #(.REC_NS(REC_NS)) mdl1 (
    .cnvst_n(cn1), .cs_n(cs1), .rd_n(rd1), .pd(pd1), .hang(1'b0), .busy(b1), .data(di1));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  function automatic bit idle_pins(input logic cn, cs, rd, pd, v, e);
    return cn && cs && rd && !pd && !v && !e;
  endfunction

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  // R4: every word presented must equal the converter's latest result
  always @(negedge clk) if (rst_n) begin
    if (v0) begin
      chk(do0 === mdl0.word, "R4 data short", int'(do0), int'(mdl0.word));
      vcnt0++;
    end
    if (v1) begin
      chk(do1 === mdl1.word, "R4 data held", int'(do1), int'(mdl1.word));
      vcnt1++;
    end
    if (e0) ecnt0++;
    if (e1) ecnt1++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int base0, base1, s0, s1, cyc, n;
    void'($urandom(32'd7411));
    rst_n = 1'b0; run = 1'b0; trig = 1'b0; pd_req = 1'b0; hang0 = 1'b0;
    repeat (10) @(negedge clk);
    chk(idle_pins(cn0, cs0, rd0, pd0, v0, e0), "R1 reset short", 0, 1);
    chk(idle_pins(cn1, cs1, rd1, pd1, v1, e1), "R1 reset held", 0, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(idle_pins(cn0, cs0, rd0, pd0, v0, e0) && mdl0.starts == 0, "R1 quiet after reset", mdl0.starts, 0);
    chk(mdl1.starts == 0, "R1 quiet after reset held", mdl1.starts, 0);

    // R2: single request
    pulse_trig();
    repeat (400) @(negedge clk);
    chk(vcnt0 == 1, "R2 single trig short", vcnt0, 1);
    chk(vcnt1 == 1, "R2 single trig held", vcnt1, 1);

    // R2: second request during conversion is ignored
    pulse_trig();
    repeat (40) @(negedge clk);
    pulse_trig();
    repeat (400) @(negedge clk);
    chk(vcnt0 == 2 && mdl0.starts == 2, "R2 trig ignored short", mdl0.starts, 2);
    chk(vcnt1 == 2 && mdl1.starts == 2, "R2 trig ignored held", mdl1.starts, 2);

    // free run
    run = 1'b1;
    repeat (4000) @(negedge clk);
    run = 1'b0;
    repeat (400) @(negedge clk);
    chk(vcnt0 == mdl0.nconv && vcnt0 > 10, "R4 all words read short", vcnt0, mdl0.nconv);
    chk(vcnt1 == mdl1.nconv && vcnt1 > 10, "R4 all words read held", vcnt1, mdl1.nconv);

    // R6/R7: power-down at random offsets during free run
    for (int k = 0; k < 3; k++) begin
      run = 1'b1;
      repeat ($urandom_range(300, 20)) @(negedge clk);
      if (k == 2) @(negedge clk iff !cn0);  // collide with a fresh start
      pd_req = 1'b1;
      n = 0;
      while (!(pd0 && pd1) && n < 1000) begin @(negedge clk); n++; end
      chk(pd0 && pd1, "R6 pd reached", n, 1000);
      chk(!b0 && vcnt0 == mdl0.nconv, "R6 finish before pd short", vcnt0, mdl0.nconv);
      chk(!b1 && vcnt1 == mdl1.nconv, "R6 finish before pd held", vcnt1, mdl1.nconv);
      s0 = mdl0.starts; s1 = mdl1.starts;
      repeat (400) @(negedge clk);
      chk(mdl0.starts == s0 && mdl1.starts == s1, "R6 no start in pd", mdl0.starts, s0);
      pd_req = 1'b0;
      n = 0;
      while (pd0 && n < 10) begin @(negedge clk); n++; end
      chk(!pd0, "R7 pd released", n, 1);
      cyc = 0;
      while (cn0 && cyc < 3000) begin @(negedge clk); cyc++; end
      chk(cyc >= REC_CYC && !cn0, "R7 recovery wait", cyc, REC_CYC);
      repeat ($urandom_range(600, 200)) @(negedge clk);
    end
    run = 1'b0;
    repeat (600) @(negedge clk);

    // R8: converter that never finishes in time
    hang0 = 1'b1;
    base0 = vcnt0; base1 = vcnt1;
    pulse_trig();
    n = 0;
    while (!e0 && n < 1500) begin @(negedge clk); n++; end
    chk(e0 && n > 400, "R8 watchdog fires", n, 480);
    @(negedge clk);
    chk(!e0, "R8 err one cycle", int'(e0), 0);
    chk(vcnt0 == base0, "R8 no word on timeout", vcnt0, base0);
    while (b0) @(negedge clk);
    repeat (200) @(negedge clk);
    hang0 = 1'b0;
    pulse_trig();
    repeat (400) @(negedge clk);
    chk(vcnt0 == base0 + 1, "R8 resumes after timeout", vcnt0, base0 + 1);
    chk(vcnt1 == base1 + 2, "R8 normal unit unaffected", vcnt1, base1 + 2);
    chk(ecnt0 == 1 && ecnt1 == 0, "R8 err count", ecnt0 * 10 + ecnt1, 10);

    // protocol rule tallies from the converter models
    chk(mdl0.overlap == 0 && mdl1.overlap == 0, "R2 no start during busy", mdl0.overlap + mdl1.overlap, 0);
    chk(mdl0.win_viol == 0, "R3 strobe window short", mdl0.win_viol, 0);
    chk(mdl1.win_viol == 0, "R3 strobe window held", mdl1.win_viol, 0);
    chk(mdl0.acq_viol == 0 && mdl1.acq_viol == 0, "R5 acquisition gap", mdl0.acq_viol + mdl1.acq_viol, 0);
    chk(mdl0.pd_viol == 0 && mdl1.pd_viol == 0, "R6 pd vs conversion", mdl0.pd_viol + mdl1.pd_viol, 0);
    chk(mdl0.rec_viol == 0 && mdl1.rec_viol == 0, "R7 recovery tally", mdl0.rec_viol + mdl1.rec_viol, 0);
    finish_run();
  end
endmodule